// File: doc/BRIEF.md
# Hierarchical Weighted Round-Robin Bus Arbiter

This block decides which of eleven requesters owns a shared memory bus next. The requesters are placed on a fixed chain of six levels. The most demanding units sit near the top of the chain and the most latency-tolerant ones sit at the bottom. Each of levels 1 to 5 has a two-way decision node. On one side is the level's own unit, or units. On the other side is the combined group of every level below it. The node splits grants between the two sides by weighted round robin. Software sets the weights through a bandwidth-control word.

The requester indices are as follows. Level 1 holds req[2:0], three CPU-side units ordered by fixed priority. Levels 2 to 5 each hold one unit: req[3], req[4], req[5] and req[6]. Level 6 holds req[10:7], a set of low-bandwidth units served in circular order. Of these, req[7] has weight 2 and the rest have weight 1. req[10] is the boot unit, which raises its request only while booting.

A grant is registered and stays one-hot until the owner pulses `xfer_done`. The grant then drops for one cycle, and the next decision is made on the edge after that.

Top module: `hwrr_arbiter`

## Requirements
- R1: While and after reset, `grant` is zero and every weight behaves as 1 until `bw_ctrl` is changed. The register's reset value is zero.
- R2: `grant` has at most one bit set. A newly issued grant goes to a requester whose `req` bit was high at the issuing edge.
- R3: A nonzero `grant` holds its value on every edge where `xfer_done` is low. On the edge where `xfer_done` is high, `grant` becomes zero.
- R4: Among req[2:0], when level 1 wins, the lowest requesting index is granted.
- R5: When `grant` is zero and any request is high, a grant is issued on the next edge, whatever the credits and wherever the requester sits. Idle levels never stall the chain.
- R6: At each level k (1 to 5) under continuous contention, the level's own side receives wl/(wl+wg) of the grants that reach node k. Here wl is the own-side weight and wg is the lower-group weight. With all weights 1, the grants alternate starting with the own side.
- R7: The weight fields of `bw_ctrl` are listed by node as own-side field / lower-group field:
  - Node 1: [17:16] / [15:14], both coded 00=1, 01=2, 10=3, 11=3.
  - Node 2: [13:12] / [11:10], both odd-coded 00=1, 01=3, 10=5, 11=5.
  - Node 3: [9:8], coded 00=1, 01=3, 10=5, 11=7 / [7:6], odd-coded.
  - Node 4: [5], coded 0=1, 1=2 / [4:3], odd-coded.
  - Node 5: [2:1], odd-coded / [0], coded 0=1, 1=2.
- R8: Level 6 serves its requesting units in ascending circular order, starting from req[7] after reset. req[7] receives 2 consecutive grants per visit and the others receive 1.
- R9: A weight change takes effect only when the node's credits next reload, which happens when both sides' credits are spent or when only one side is requesting. Credit that is already loaded is used up first.
- R10: Bits [25:18] of `bw_ctrl` have no effect on grants.
- R11: With no request high and `grant` zero, `grant` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 11 | Request vector, indices as described above |
| bw_ctrl | input | 26 | Bandwidth-control word holding the weight fields |
| xfer_done | input | 1 | One-cycle pulse from the owner marking the end of its transfer |
| grant | output | 11 | One-hot grant vector |

## Verification
The assertions assume three things about the inputs. A requester keeps its request high until it is granted. `xfer_done` is pulsed only while a grant is held. `req` is quiet during reset. The bench follows these assumptions in every test. It changes `req` and `bw_ctrl` only on the falling edge while `grant` is zero, raises `xfer_done` for exactly one cycle after it sees a grant, and holds `req` at zero during reset. The random requester patterns and control words come from a fixed seed and are applied only between transfers. This keeps the share measurements tied to a single, known setting.

// File: rtl/hwrr_pkg.sv
// Package: shared weight type and decode helpers for the arbiter.
// Assumes weights never exceed 7, so 3 bits suffice.
package hwrr_pkg;
    localparam int WW = 3;
    typedef logic [WW-1:0] wgt_t;
    localparam wgt_t W_ONE = 3'd1;

    // Decode a 1/2/3 field; code 11 saturates to 3.
    function automatic wgt_t dec_lin(input logic [1:0] c);
        case (c)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

    // Decode an odd-valued field; code 11 gives 7 only where permitted.
    function automatic wgt_t dec_odd(input logic [1:0] c, input logic allow7);
        if (c == 2'b11) return allow7 ? 3'd7 : 3'd5;
        return {c, 1'b1};
    endfunction

    // Decode a single-bit field: 0 gives 1, 1 gives 2.
    function automatic wgt_t dec_one(input logic b);
        return b ? 3'd2 : 3'd1;
    endfunction
endpackage

// File: rtl/hwrr_node.sv
// Two-way weighted round-robin node: own side versus the lower group.
// Each side holds a credit count. When both counts are spent, the weights
// are used as fresh credit. A lone requesting side wins at once and reloads
// both counts. State moves only when 'advance' is high.
module hwrr_node
    import hwrr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req,
    input  logic grp_req,
    input  wgt_t loc_w,
    input  wgt_t grp_w,
    input  logic advance,
    output logic pick_loc
);
    wgt_t cred_l, cred_g;
    wgt_t eff_l, eff_g;
    logic spent;

    // Effective credit: reload from the weights when both sides are spent.
    always_comb begin
        spent = (cred_l == '0) && (cred_g == '0);
        eff_l = spent ? loc_w : cred_l;
        eff_g = spent ? grp_w : cred_g;
        pick_loc = loc_req && (!grp_req || (eff_l != '0));
    end

    // Credit update on a decision that passes through this node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_l <= '0;
            cred_g <= '0;
        end else if (advance) begin
            if (loc_req && grp_req) begin
                if (pick_loc) begin
                    cred_l <= eff_l - W_ONE;
                    cred_g <= eff_g;
                end else begin
                    cred_l <= eff_l;
                    cred_g <= eff_g - W_ONE;
                end
            end else begin
                cred_l <= loc_w;
                cred_g <= grp_w;
            end
        end
    end
endmodule

// File: rtl/hwrr_low.sv
// Bottom-level circular arbiter with fixed per-unit weights.
// The current unit keeps winning while it requests and has credit left.
// Otherwise the next requesting unit in circular order wins and loads its
// weight minus one as credit. Assumes every weight in WEIGHTS is at least 1.
module hwrr_low
    import hwrr_pkg::*;
#(
    parameter int N = 4,
    parameter logic [N*WW-1:0] WEIGHTS = {3'd1, 3'd1, 3'd1, 3'd2},
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [PW-1:0] sel
);
    logic [PW-1:0] ptr;
    wgt_t          cred;
    logic          stay;
    logic          found;

    // Choose: stay on the current unit, or search onward from it.
    always_comb begin
        stay  = req[ptr] && (cred != '0);
        sel   = ptr;
        found = stay;
        for (int off = 1; off <= N; off++) begin
            int j;
            j = int'(ptr) + off;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                sel   = PW'(j);
                found = 1'b1;
            end
        end
    end

    // Pointer and credit update when this level is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= PW'(N - 1);
            cred <= '0;
        end else if (advance) begin
            if (stay) begin
                cred <= cred - W_ONE;
            end else begin
                ptr  <= sel;
                cred <= WEIGHTS[int'(sel)*WW +: WW] - W_ONE;
            end
        end
    end
endmodule

// File: rtl/hwrr_arbiter.sv
// Six-level hierarchical weighted round-robin bus arbiter.
// Nodes 1 to 5 each weigh their own level against all deeper levels.
// Level 1 is a fixed-priority set of units, levels 2 to 5 hold one unit
// each, and level 6 is a circular set. A grant is registered and held
// until xfer_done; the next decision is made on the edge after grant drops.
// Assumes requesters hold req until granted.
module hwrr_arbiter
    import hwrr_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int N_LOW  = 4,
    parameter int CTRL_W = 26,
    parameter logic [N_LOW*WW-1:0] LOW_WEIGHTS = {3'd1, 3'd1, 3'd1, 3'd2},
    localparam int N_MID    = 4,
    localparam int N_NODE   = N_MID + 1,
    localparam int LOW_BASE = N_CPU + N_MID,
    localparam int N_REQ    = LOW_BASE + N_LOW,
    localparam int LPW      = (N_LOW > 1) ? $clog2(N_LOW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req,
    input  logic [CTRL_W-1:0] bw_ctrl,
    input  logic              xfer_done,
    output logic [N_REQ-1:0]  grant
);
    logic [N_NODE:0]   lvl_req;
    logic [N_NODE-1:0] grp_req;
    logic [N_NODE-1:0] pick_loc;
    logic [N_NODE-1:0] node_adv;
    logic [N_NODE:0]   on_path;
    wgt_t              loc_w [N_NODE];
    wgt_t              grp_w [N_NODE];
    logic [LPW-1:0]    low_sel;
    logic [N_REQ-1:0]  win;
    logic              issue;
    logic              unused_rsvd;

    assign unused_rsvd = ^bw_ctrl[CTRL_W-1:18];

    // Per-level request summary.
    always_comb begin
        lvl_req[0] = |req[N_CPU-1:0];
        for (int k = 1; k <= N_MID; k++) lvl_req[k] = req[N_CPU+k-1];
        lvl_req[N_NODE] = |req[N_REQ-1:LOW_BASE];
    end

    // Weight field decode for each node.
    always_comb begin
        loc_w[0] = dec_lin(bw_ctrl[17:16]);
        grp_w[0] = dec_lin(bw_ctrl[15:14]);
        loc_w[1] = dec_odd(bw_ctrl[13:12], 1'b0);
        grp_w[1] = dec_odd(bw_ctrl[11:10], 1'b0);
        loc_w[2] = dec_odd(bw_ctrl[9:8], 1'b1);
        grp_w[2] = dec_odd(bw_ctrl[7:6], 1'b0);
        loc_w[3] = dec_one(bw_ctrl[5]);
        grp_w[3] = dec_odd(bw_ctrl[4:3], 1'b0);
        loc_w[4] = dec_odd(bw_ctrl[2:1], 1'b0);
        grp_w[4] = dec_one(bw_ctrl[0]);
    end

    assign issue = (grant == '0) && (req != '0);

    // Decision path: a node is visited when every node above chose the group side.
    always_comb begin
        on_path[0] = 1'b1;
        for (int k = 0; k < N_NODE; k++) on_path[k+1] = on_path[k] && !pick_loc[k];
    end

    genvar gk;
    generate
        for (gk = 0; gk < N_NODE; gk++) begin : g_node
            assign grp_req[gk]  = |lvl_req[N_NODE:gk+1];
            assign node_adv[gk] = issue && on_path[gk];
            hwrr_node u_node (
                .clk      (clk),
                .rst_n    (rst_n),
                .loc_req  (lvl_req[gk]),
                .grp_req  (grp_req[gk]),
                .loc_w    (loc_w[gk]),
                .grp_w    (grp_w[gk]),
                .advance  (node_adv[gk]),
                .pick_loc (pick_loc[gk])
            );
        end
    endgenerate

    hwrr_low #(.N(N_LOW), .WEIGHTS(LOW_WEIGHTS)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req[N_REQ-1:LOW_BASE]),
        .advance (issue && on_path[N_NODE]),
        .sel     (low_sel)
    );

    // Winner vector: lowest CPU index, a middle unit, or the bottom-level choice.
    always_comb begin
        win = '0;
        if (pick_loc[0]) begin
            for (int i = N_CPU - 1; i >= 0; i--) begin
                if (req[i]) begin
                    win    = '0;
                    win[i] = 1'b1;
                end
            end
        end
        for (int k = 1; k <= N_MID; k++) begin
            if (on_path[k] && pick_loc[k]) win[N_CPU+k-1] = 1'b1;
        end
        if (on_path[N_NODE]) win[LOW_BASE + int'(low_sel)] = 1'b1;
    end

    // Grant register: issue when free, release on transfer done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else if (issue) begin
            grant <= win;
        end else if (xfer_done) begin
            grant <= '0;
        end
    end
endmodule

// File: rtl/hwrr_arbiter_chk.sv
// Checker for hwrr_arbiter: grant shape, hold and release, and priority.
// Assumes requesters hold req until granted and xfer_done comes only during a grant.
module hwrr_arbiter_chk #(
    parameter int N_CPU = 3,
    parameter int N_REQ = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic             xfer_done,
    input logic [N_REQ-1:0] grant
);
    logic [N_CPU-1:0] cpu_g;
    logic [N_CPU-1:0] cpu_below;

    assign cpu_g     = grant[N_CPU-1:0];
    assign cpu_below = cpu_g - {{(N_CPU-1){1'b0}}, 1'b1};

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ($past(grant) == '0)) |-> (($past(req) & grant) != '0)); // R2

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !xfer_done) |=> (grant == $past(grant))); // R3

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && xfer_done) |=> (grant == '0)); // R3

    AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (req != '0)) |=> (grant != '0)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (req == '0)) |=> (grant == '0)); // R11

    AST_CPU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_g != '0) && ($past(grant) == '0)) |-> ((cpu_below & $past(req[N_CPU-1:0])) == '0)); // R4
endmodule

bind hwrr_arbiter hwrr_arbiter_chk #(.N_CPU(N_CPU), .N_REQ(N_REQ)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .xfer_done (xfer_done),
    .grant     (grant)
);

// File: tb/hwrr_arbiter_tb_top.sv
// Bench: directed corner cases, share measurements and seeded random patterns.
module hwrr_arbiter_tb_top;
    localparam int NR = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] req = '0;
    logic [25:0]   bw_ctrl = '0;
    logic          xfer_done = 1'b0;
    logic [NR-1:0] grant;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    hwrr_arbiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .bw_ctrl   (bw_ctrl),
        .xfer_done (xfer_done),
        .grant     (grant)
    );

    // Record one check.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Index of the single set bit; -1 for none, -2 for several.
    function automatic int gidx(input logic [NR-1:0] g);
        int r;
        r = -1;
        for (int i = 0; i < NR; i++) if (g[i]) r = (r == -1) ? i : -2;
        return r;
    endfunction

    // Level (1..6) of a requester index.
    function automatic int lvl_of(input int i);
        if (i < 3) return 1;
        if (i < 7) return i - 1;
        return 6;
    endfunction

    function automatic int d_lin(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 3;
    endfunction
    function automatic int d_odd(input logic [1:0] c, input bit a7);
        return (c == 2'b11) ? (a7 ? 7 : 5) : 2 * int'(c) + 1;
    endfunction
    function automatic int d_one(input logic b);
        return b ? 2 : 1;
    endfunction

    // Expected own-side and group weights of node k (1..5) per R7.
    function automatic int w_loc(input logic [25:0] r, input int k);
        case (k)
            1: return d_lin(r[17:16]);
            2: return d_odd(r[13:12], 1'b0);
            3: return d_odd(r[9:8], 1'b1);
            4: return d_one(r[5]);
            default: return d_odd(r[2:1], 1'b0);
        endcase
    endfunction
    function automatic int w_grp(input logic [25:0] r, input int k);
        case (k)
            1: return d_lin(r[15:14]);
            2: return d_odd(r[11:10], 1'b0);
            3: return d_odd(r[7:6], 1'b0);
            4: return d_odd(r[4:3], 1'b0);
            default: return d_one(r[0]);
        endcase
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reset with inputs quiet; ends on a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        req = '0;
        xfer_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One transfer: wait for the grant, check it, hold, pulse done, check release.
    task automatic xfer(input int hold, output int g);
        int w;
        logic [NR-1:0] held;
        w = 0;
        @(negedge clk);
        while (grant == '0 && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk(w <= 1, "R5 grant delay", w, 1);
        g = gidx(grant);
        chk(g >= 0, "R2 one-hot", g, 0);
        if (g >= 0) chk(req[g] == 1'b1, "R2 granted bit requested", g, g);
        held = grant;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(grant == held, "R3 grant held", gidx(grant), gidx(held));
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(grant == '0, "R3 release after done", gidx(grant), -1);
    endtask

    // Expect a given requester on the next transfer.
    task automatic expect_next(input int e, input string tag);
        int g;
        xfer(0, g);
        chk(g == e, tag, g, e);
    endtask

    // Full contention for n grants; compare each node's split with R6.
    task automatic share_run(input logic [25:0] r, input int n);
        int cnt[7];
        int c7;
        int g;
        do_reset();
        bw_ctrl = r;
        req = '1;
        for (int i = 0; i < 7; i++) cnt[i] = 0;
        c7 = 0;
        for (int t = 0; t < n; t++) begin
            xfer(0, g);
            if (g >= 0) begin
                cnt[lvl_of(g)]++;
                if (g == 7) c7++;
            end
        end
        for (int k = 1; k <= 5; k++) begin
            int d, wl, wg, s;
            d = 0;
            for (int m = k; m <= 6; m++) d += cnt[m];
            wl = w_loc(r, k);
            wg = w_grp(r, k);
            s = wl + wg;
            chk(iabs(cnt[k] * s - d * wl) <= s * s, $sformatf("R6 R7 node %0d share", k),
                cnt[k] * s, d * wl);
        end
        chk(iabs(c7 * 5 - cnt[6] * 2) <= 25, "R8 level-6 weighted share", c7 * 5, cnt[6] * 2);
        req = '0;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int g;
        int gs [7];
        void'($urandom(32'd4242));

        // R1 and R11: quiet after reset.
        do_reset();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(grant == '0, "R1 R11 no grant at rest", gidx(grant), -1);
        end

        // R1 and R6: reset weights alternate levels 2 and 3 starting with the own side.
        do_reset();
        req = 11'b000_0001_1000;
        expect_next(3, "R1 R6 alternate");
        expect_next(4, "R1 R6 alternate");
        expect_next(3, "R1 R6 alternate");
        expect_next(4, "R1 R6 alternate");

        // R10: reserved bits set, same sequence.
        do_reset();
        bw_ctrl = 26'h3FC0000;
        req = 11'b000_0001_1000;
        expect_next(3, "R10 reserved ignored");
        expect_next(4, "R10 reserved ignored");
        expect_next(3, "R10 reserved ignored");
        bw_ctrl = '0;

        // R4: fixed priority inside level 1.
        do_reset();
        req = 11'b000_0000_0110;
        expect_next(1, "R4 lowest index");
        expect_next(1, "R4 lowest index");
        req = 11'b000_0000_0101;
        expect_next(0, "R4 lowest index");

        // R8: level-6 circular order with weight 2 on index 7.
        do_reset();
        req = 11'b111_1000_0000;
        gs = '{7, 7, 8, 9, 10, 7, 7};
        for (int i = 0; i < 7; i++) expect_next(gs[i], "R8 order with boot unit");
        do_reset();
        req = 11'b011_1000_0000;
        gs = '{7, 7, 8, 9, 7, 7, 8};
        for (int i = 0; i < 7; i++) expect_next(gs[i], "R8 order without boot unit");

        // R9: a new weight waits for the next reload.
        do_reset();
        req = 11'b000_0001_1000;
        expect_next(3, "R9 before change");
        bw_ctrl = 26'h0002000;
        gs = '{4, 3, 3, 3, 3, 3, 4};
        for (int i = 0; i < 7; i++) expect_next(gs[i], "R9 after change");
        bw_ctrl = '0;

        // R3: long hold with done low.
        do_reset();
        req = 11'b000_0000_0001;
        xfer(8, g);
        chk(g == 0, "R3 held owner", g, 0);

        // R5: a lone deep requester is served at once.
        do_reset();
        req = 11'b100_0000_0000;
        expect_next(10, "R5 lone deepest");
        req = 11'b000_0100_0000;
        expect_next(6, "R5 lone level 5");

        // R6 and R7: shares at several settings.
        share_run(26'h0000000, 2400);
        share_run(26'h0022371, 2400);
        share_run(26'h000CC99, 2400);

        // Seeded random patterns between transfers.
        do_reset();
        for (int t = 0; t < 300; t++) begin
            logic [NR-1:0] r;
            r = NR'($urandom) & NR'($urandom);
            bw_ctrl = 26'($urandom);
            req = r;
            if (r == '0) begin
                repeat (3) begin
                    @(negedge clk);
                    chk(grant == '0, "R11 random idle", gidx(grant), -1);
                end
            end else begin
                xfer(0, g);
                if (g >= 0 && g < 3) begin
                    for (int i = 0; i < g; i++)
                        chk(r[i] == 1'b0, "R4 random priority", i, g);
                end
            end
        end
        req = '0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule